// File: doc/BRIEF.md
# Eight-Level Vectored Interrupt Controller

This block chooses which of eight prioritised interrupt levels the CPU serves next. It then hands over the call target for that level as a vector address and as the one-byte call opcode that jumps there. Eleven hardware request lines feed the block. Each line has its own enable bit and a programmable three-bit level, and any line that fires sets the pending bit of its level. Software can also load the whole eight-bit pending register from two four-bit values, either to raise a level by hand or to defer work to a lower level. A software-set bit is treated exactly like one set by hardware.

Levels can nest. The block holds one active bit per level. A pending level is granted only when it ranks strictly above the highest level now in service. A return strobe retires the highest active level, and a lower waiting level can then be granted. A per-level mask input stops a level from being granted while its pending bit is kept.

The control is a two-state machine:
- `ST_IDLE` waits for an eligible level. Transition *grant* (`ST_IDLE` to `ST_CALL`) fires in the cycle a level wins. In that same cycle the level's active bit is set, its pending bit is cleared and the output registers are loaded.
- `ST_CALL` presents the vector for exactly one cycle. Transition *release* (`ST_CALL` to `ST_IDLE`) is taken unconditionally.

Top module: `vic8_ctrl`

## Requirements
- R1: When several levels are pending and unmasked with no level active, level 7 wins over all others and level 0 loses to all others. Levels are numbered 0..7, and `swi_hi` carries pending bits 7..4 while `swi_lo` carries bits 3..0.
- R2: The vector address for levels 0..6 is (level+1)·0x40, giving 0x040 to 0x1C0. Level 7 uses 0x1E0.
- R3: The call opcode is 0xC0 OR (vector address >> 3). This gives C8, D0, D8, E0, E8, F0, F8 and FC for levels 0..7.
- R4: A pending level is granted only if it is strictly higher than the highest active level. An equal or lower level stays pending.
- R5: A grant in cycle n sets that level's active bit and clears its pending bit at the end of cycle n. `vec_valid` is high for exactly cycle n+1, and no grant happens during that cycle.
- R6: A `reti` pulse clears the highest set active bit. A lower pending level is then granted on the following cycles.
- R7: Configuration writes a source's enable bit and level, selected by index 0..10 (other index values are ignored). A disabled source never sets a pending bit. An enabled level-type source sets the pending bit of its assigned level in every cycle its line is high.
- R8: Sources marked as edge-type in `EDGE_SRC` (default: sources 0 and 1) set their pending bit on both rising and falling edges of the line. They do not re-trigger while the line is held.
- R9: A software write replaces the pending register with {`swi_hi`,`swi_lo`}. Hardware sets that arrive in the same cycle are ORed into the result.
- R10: A level whose bit in `lvl_enable` is 0 is never granted, but its pending bit is kept. The level is granted once it is unmasked.
- R11: Synchronous reset clears the pending, active and source enable registers, and no vector is issued after reset until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | 11 | Hardware request lines |
| cfg_we | input | 1 | Source configuration write strobe |
| cfg_sel | input | 4 | Source index for configuration |
| cfg_en | input | 1 | Enable bit to write |
| cfg_lvl | input | 3 | Level to assign |
| lvl_enable | input | 8 | Per-level mask, 1 = may be granted |
| swi_we | input | 1 | Software pending-register write strobe |
| swi_hi | input | 4 | Value for pending bits 7..4 |
| swi_lo | input | 4 | Value for pending bits 3..0 |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_valid | output | 1 | One-cycle vector strobe |
| vec_level | output | 3 | Granted level |
| vec_addr | output | 9 | Vector address |
| vec_opcode | output | 8 | Call opcode byte |

## Verification
The bench holds one level in service and re-raises that same level, then a lower one. A design that preempts on equal rank or ignores rank would emit a nested vector too early. It drives a software write and a hardware set to different levels in the same cycle. A design where the write overwrites the hardware set loses the second vector. It also masks a pending level, holds an edge-type line steady, and pulses a disabled source; a design that drops the masked bit, re-triggers on a steady level or ignores the enable would show a missing or extra vector. A cycle-accurate bench model, driven by randomly mixed requests, writes and returns, compares every output cycle, including the level 7 address that breaks the regular spacing.

// File: rtl/vic8_pkg.sv
package vic8_pkg;
    localparam int NLVL = 8;
    localparam int NSRC = 11;
    localparam int LW   = $clog2(NLVL);
    localparam int SW   = $clog2(NSRC);
    localparam int AW   = 9;
    localparam int HALF = NLVL / 2;

    typedef enum logic {ST_IDLE = 1'b0, ST_CALL = 1'b1} vic_state_e;

    // top level sits half a slot above the regular spacing
    function automatic logic [AW-1:0] vec_addr_of(input logic [LW-1:0] lvl);
        logic [AW-1:0] base;
        base = AW'(lvl) << 6;
        if (lvl == LW'(NLVL - 1)) vec_addr_of = base + AW'(32);
        else                      vec_addr_of = base + AW'(64);
    endfunction

    function automatic logic [7:0] opcode_of(input logic [AW-1:0] addr);
        opcode_of = 8'hC0 | 8'(addr >> 3);
    endfunction
endpackage

// File: rtl/vic8_src_bank.sv
module vic8_src_bank
    import vic8_pkg::*;
#(
    parameter int                NS       = NSRC,
    parameter logic [NSRC-1:0]   EDGE_SRC = 11'b000_0000_0011
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NS-1:0]   src_req,
    input  logic            cfg_we,
    input  logic [SW-1:0]   cfg_sel,
    input  logic            cfg_en,
    input  logic [LW-1:0]   cfg_lvl,
    output logic [NLVL-1:0] hw_set
);
    logic [NS-1:0] en_q;
    logic [NS-1:0] req_q;
    logic [NS-1:0] fire;
    logic [LW-1:0] lvl_q [NS];

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= src_req;
    end

    for (genvar g = 0; g < NS; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[g]  <= 1'b0;
                lvl_q[g] <= '0;
            end else if (cfg_we && cfg_sel == SW'(g)) begin
                en_q[g]  <= cfg_en;
                lvl_q[g] <= cfg_lvl;
            end
        end
        if (EDGE_SRC[g]) begin : g_edge
            assign fire[g] = en_q[g] & (src_req[g] ^ req_q[g]);
        end else begin : g_level
            assign fire[g] = en_q[g] & src_req[g];
        end
    end

    always_comb begin
        hw_set = '0;
        for (int i = 0; i < NS; i++)
            if (fire[i]) hw_set[lvl_q[i]] = 1'b1;
    end

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> (hw_set == '0)); // R7
endmodule

// File: rtl/vic8_level_regs.sv
module vic8_level_regs
    import vic8_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NLVL-1:0] hw_set,
    input  logic            swi_we,
    input  logic [HALF-1:0] swi_hi,
    input  logic [HALF-1:0] swi_lo,
    input  logic [NLVL-1:0] take_mask,
    input  logic            reti,
    output logic [NLVL-1:0] pend_q,
    output logic [NLVL-1:0] act_q
);
    logic [NLVL-1:0] base;
    logic [NLVL-1:0] top_act;

    always_comb begin
        top_act = '0;
        for (int i = 0; i < NLVL; i++)
            if (act_q[i]) top_act = NLVL'(1) << i;
    end

    assign base = swi_we ? {swi_hi, swi_lo} : pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            pend_q <= (base & ~take_mask) | hw_set;
            act_q  <= (act_q & ~(reti ? top_act : '0)) | take_mask;
        end
    end

    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take_mask)); // R5
    AST_RETI_DROP: assert property (@(posedge clk) disable iff (rst)
        (reti && act_q != '0 && take_mask == '0) |=>
        ($countones(act_q) == $past($countones(act_q)) - 1)); // R6
endmodule

// File: rtl/vic8_arbiter.sv
module vic8_arbiter
    import vic8_pkg::*;
(
    input  logic [NLVL-1:0] pend_q,
    input  logic [NLVL-1:0] act_q,
    input  logic [NLVL-1:0] lvl_enable,
    output logic            win,
    output logic [LW-1:0]   win_lvl
);
    logic [NLVL-1:0] elig;
    logic [LW-1:0]   act_top;

    assign elig = pend_q & lvl_enable;

    always_comb begin
        win_lvl = '0;
        act_top = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (elig[i])  win_lvl = LW'(i);
            if (act_q[i]) act_top = LW'(i);
        end
        win = (elig != '0) && ((act_q == '0) || (win_lvl > act_top));
    end
endmodule

// File: rtl/vic8_ctrl.sv
module vic8_ctrl
    import vic8_pkg::*;
#(
    parameter logic [NSRC-1:0] EDGE_SRC = 11'b000_0000_0011
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_req,
    input  logic            cfg_we,
    input  logic [SW-1:0]   cfg_sel,
    input  logic            cfg_en,
    input  logic [LW-1:0]   cfg_lvl,
    input  logic [NLVL-1:0] lvl_enable,
    input  logic            swi_we,
    input  logic [HALF-1:0] swi_hi,
    input  logic [HALF-1:0] swi_lo,
    input  logic            reti,
    output logic            vec_valid,
    output logic [LW-1:0]   vec_level,
    output logic [AW-1:0]   vec_addr,
    output logic [7:0]      vec_opcode
);
    vic_state_e      state_q, state_d;
    logic [NLVL-1:0] hw_set, pend_q, act_q, take_mask;
    logic            win, grant;
    logic [LW-1:0]   win_lvl;

    vic8_src_bank #(.NS(NSRC), .EDGE_SRC(EDGE_SRC)) i_src (
        .clk(clk), .rst(rst), .src_req(src_req), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_lvl(cfg_lvl), .hw_set(hw_set));

    vic8_arbiter i_arb (
        .pend_q(pend_q), .act_q(act_q), .lvl_enable(lvl_enable),
        .win(win), .win_lvl(win_lvl));

    assign grant     = (state_q == ST_IDLE) && win;
    assign take_mask = grant ? (NLVL'(1) << win_lvl) : '0;

    vic8_level_regs i_regs (
        .clk(clk), .rst(rst), .hw_set(hw_set), .swi_we(swi_we),
        .swi_hi(swi_hi), .swi_lo(swi_lo), .take_mask(take_mask),
        .reti(reti), .pend_q(pend_q), .act_q(act_q));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (win) state_d = ST_CALL;   // grant
            ST_CALL: state_d = ST_IDLE;            // release
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid  <= 1'b0;
            vec_level  <= '0;
            vec_addr   <= '0;
            vec_opcode <= '0;
        end else begin
            vec_valid <= grant;
            if (grant) begin
                vec_level  <= win_lvl;
                vec_addr   <= vec_addr_of(win_lvl);
                vec_opcode <= opcode_of(vec_addr_of(win_lvl));
            end
        end
    end

    AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid); // R5
    AST_OPCODE_MATCH: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_opcode == (8'hC0 | 8'(vec_addr >> 3)))); // R3
    AST_NEST_TOP: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> ((act_q >> vec_level) == NLVL'(1))); // R4
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!vec_valid && act_q == '0 && pend_q == '0)); // R11
endmodule

// File: tb/test_vic8_ctrl.sv
module test_vic8_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [10:0] EDGES = 11'b000_0000_0011;

    logic        clk = 1'b0, rst = 1'b1;
    logic [10:0] src_req = '0;
    logic        cfg_we = 0, cfg_en = 0, swi_we = 0, reti = 0;
    logic [3:0]  cfg_sel = '0, swi_hi = '0, swi_lo = '0;
    logic [2:0]  cfg_lvl = '0;
    logic [7:0]  lvl_enable = 8'hFF;
    logic        vec_valid;
    logic [2:0]  vec_level;
    logic [8:0]  vec_addr;
    logic [7:0]  vec_opcode;
    int checks = 0, errors = 0;
    bit done = 0;

    vic8_ctrl #(.EDGE_SRC(EDGES)) i_vic8_ctrl (
        .clk(clk), .rst(rst), .src_req(src_req), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_en(cfg_en), .cfg_lvl(cfg_lvl), .lvl_enable(lvl_enable), .swi_we(swi_we),
        .swi_hi(swi_hi), .swi_lo(swi_lo), .reti(reti), .vec_valid(vec_valid),
        .vec_level(vec_level), .vec_addr(vec_addr), .vec_opcode(vec_opcode));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [8:0] exp_addr(input logic [2:0] l);
        case (l)
            3'd0: return 9'h040; 3'd1: return 9'h080; 3'd2: return 9'h0C0;
            3'd3: return 9'h100; 3'd4: return 9'h140; 3'd5: return 9'h180;
            3'd6: return 9'h1C0; default: return 9'h1E0;
        endcase
    endfunction
    function automatic logic [7:0] exp_op(input logic [2:0] l);
        case (l)
            3'd0: return 8'hC8; 3'd1: return 8'hD0; 3'd2: return 8'hD8;
            3'd3: return 8'hE0; 3'd4: return 8'hE8; 3'd5: return 8'hF0;
            3'd6: return 8'hF8; default: return 8'hFC;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- bench model, built from the requirements ----------------
    logic       m_en [11];
    logic [2:0] m_lvl [11];
    logic [10:0] m_prev;
    logic [7:0] m_pend, m_act, m_hw, m_elig, m_base;
    logic       m_call, m_valid, m_take;
    logic [2:0] m_out, m_h, m_a;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 11; i++) begin m_en[i] = 0; m_lvl[i] = 0; end
            m_prev = '0; m_pend = '0; m_act = '0; m_call = 0; m_valid = 0; m_out = '0;
        end else begin
            m_hw = '0;
            for (int i = 0; i < 11; i++)
                if (m_en[i] && (EDGES[i] ? (src_req[i] != m_prev[i]) : src_req[i]))
                    m_hw[m_lvl[i]] = 1'b1;
            m_elig = m_pend & lvl_enable;
            m_h = 0; m_a = 0;
            for (int i = 0; i < 8; i++) begin
                if (m_elig[i]) m_h = 3'(i);
                if (m_act[i])  m_a = 3'(i);
            end
            m_take = !m_call && m_elig != 0 && (m_act == 0 || m_h > m_a);
            m_base = swi_we ? {swi_hi, swi_lo} : m_pend;
            if (m_take) m_base[m_h] = 1'b0;
            m_pend = m_base | m_hw;
            if (reti && m_act != 0) m_act[m_a] = 1'b0;
            if (m_take) m_act[m_h] = 1'b1;
            if (cfg_we && cfg_sel < 11) begin m_en[cfg_sel] = cfg_en; m_lvl[cfg_sel] = cfg_lvl; end
            m_prev = src_req;
            m_call = m_take; m_valid = m_take;
            if (m_take) m_out = m_h;
        end
    end

    always @(negedge clk) if (!rst && !done) begin
        check(vec_valid == m_valid, "R5 strobe vs model", vec_valid, m_valid);
        if (m_valid) begin
            check(vec_level == m_out, "R1 level vs model", vec_level, m_out);
            check(vec_addr == exp_addr(m_out), "R2 address", vec_addr, exp_addr(m_out));
            check(vec_opcode == exp_op(m_out), "R3 opcode", vec_opcode, exp_op(m_out));
        end
    end

    // ---------------- directed helpers ----------------
    task automatic wait_vec(input logic [2:0] l, input string tag);
        bit seen = 0;
        for (int k = 0; k < 20 && !seen; k++) begin
            @(negedge clk);
            if (vec_valid) seen = 1;
        end
        check(seen, tag, 0, 1);
        if (seen) begin
            check(vec_level == l, tag, vec_level, l);
            check(vec_addr == exp_addr(l), tag, vec_addr, exp_addr(l));
            check(vec_opcode == exp_op(l), tag, vec_opcode, exp_op(l));
        end
    endtask
    task automatic expect_none(input int n, input string tag);
        bit any = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (vec_valid) any = 1;
        end
        check(!any, tag, any, 0);
    endtask
    task automatic pulse_reti();
        reti = 1; @(negedge clk); reti = 0;
    endtask
    task automatic sw_write(input logic [7:0] v);
        swi_we = 1; {swi_hi, swi_lo} = v; @(negedge clk); swi_we = 0;
    endtask
    task automatic cfg(input int s, input logic e, input logic [2:0] l);
        cfg_we = 1; cfg_sel = 4'(s); cfg_en = e; cfg_lvl = l; @(negedge clk); cfg_we = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        check(vec_valid == 0, "R11 reset output", vec_valid, 0);
        expect_none(5, "R11 quiet after reset");

        sw_write(8'h81);               // levels 7 and 0
        wait_vec(7, "R1 highest first");
        expect_none(6, "R4 lower waits");
        pulse_reti();
        wait_vec(0, "R6 lower after return");
        pulse_reti();

        lvl_enable = 8'hF7; sw_write(8'h08);
        expect_none(5, "R10 masked level");
        lvl_enable = 8'hFF;
        wait_vec(3, "R10 unmasked later");
        pulse_reti();

        sw_write(8'h20); wait_vec(5, "R5 grant");
        sw_write(8'h20); expect_none(5, "R4 equal level waits");
        pulse_reti(); wait_vec(5, "R6 equal after return");
        pulse_reti();

        sw_write(8'h04); wait_vec(2, "R4 base");
        sw_write(8'h40); wait_vec(6, "R4 preempt higher");
        pulse_reti(); expect_none(4, "R6 nothing left"); pulse_reti();

        cfg(5, 0, 3'd6);
        src_req[5] = 1; @(negedge clk); src_req[5] = 0;
        expect_none(5, "R7 disabled source");
        cfg(15, 1, 3'd1);               // out-of-range index ignored
        src_req[5] = 1; @(negedge clk); src_req[5] = 0;
        expect_none(5, "R7 bad index ignored");
        cfg(5, 1, 3'd6);
        src_req[5] = 1; @(negedge clk); src_req[5] = 0;
        wait_vec(6, "R7 enabled source level");
        pulse_reti();

        cfg(0, 1, 3'd2);
        src_req[0] = 1; wait_vec(2, "R8 rising edge");
        pulse_reti(); expect_none(5, "R8 held line no retrigger");
        src_req[0] = 0; wait_vec(2, "R8 falling edge");
        pulse_reti();

        cfg(5, 1, 3'd2);
        swi_we = 1; {swi_hi, swi_lo} = 8'h10; src_req[5] = 1;
        @(negedge clk); swi_we = 0; src_req[5] = 0;
        wait_vec(4, "R9 software bit");
        pulse_reti();
        wait_vec(2, "R9 hardware bit merged");
        pulse_reti();
        repeat (4) @(negedge clk);

        void'($urandom(32'h5eed_0042));
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            cfg_we = ($urandom_range(0, 29) == 0);
            cfg_sel = 4'($urandom_range(0, 11));
            cfg_en = ($urandom_range(0, 3) != 0);
            cfg_lvl = 3'($urandom);
            if ($urandom_range(0, 5) == 0) src_req[$urandom_range(0, 10)] ^= 1'b1;
            swi_we = ($urandom_range(0, 39) == 0);
            {swi_hi, swi_lo} = 8'($urandom);
            reti = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 99) == 0) lvl_enable = 8'($urandom) | 8'h81;
        end
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1; checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule